// File: doc/BRIEF.md
# Two-bit burst address sequencer

This block produces the two least significant address bits for a four-beat burst into a synchronous memory. It has two independent address strobes, one for a processor and one for a controller. When either strobe is sampled active on a rising clock edge, the block captures the two-bit start offset presented with it. After that, each clock edge with the advance input high steps the burst one beat onward.

A static mode input selects the burst order. The interleaved order XORs the start offset with the beat number. The linear order adds the beat number to the start offset and wraps modulo four. The block never carries into higher address bits. A flag marks the fourth beat of the burst. After that beat the sequence starts again from the captured start offset.

Top module: `burst_seq`

## Requirements
- R1: A synchronous active-high reset sets the offset to 0, lowers the last-beat flag and sets the captured start offset to 0.
- R2: When `strobe_proc` or `strobe_ctrl` (or both) is high at a rising edge, the offset after that edge equals `start_addr`, the burst is at beat 0 and `last_beat` is low.
- R3: With `lin_mode` = 0 (interleaved), the offset on beat k (k = 0..3) equals start XOR k. For example, start 1 gives 1, 0, 3, 2.
- R4: With `lin_mode` = 1 (linear), the offset on beat k equals (start + k) mod 4. For example, start 2 gives 2, 3, 0, 1.
- R5: On an edge with no strobe and `adv` low, the offset and `last_beat` keep their values.
- R6: When a strobe and `adv` are both high at the same edge, the strobe wins: the new start is loaded and the burst returns to beat 0.
- R7: `last_beat` is high exactly while the burst is on its fourth beat (beat 3).
- R8: Advancing from beat 3 wraps back to beat 0, so the offset returns to the captured start value and the sequence repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_proc | input | 1 | Processor address strobe, starts a burst |
| strobe_ctrl | input | 1 | Controller address strobe, starts a burst |
| adv | input | 1 | Step to the next beat |
| lin_mode | input | 1 | 0 = interleaved order, 1 = linear order |
| start_addr | input | 2 | Low address bits captured by a strobe |
| offset | output | 2 | Current burst offset |
| last_beat | output | 1 | High on the fourth beat |

## Verification
Strobe, advance and reset act at a single rising edge. `offset` and `last_beat` are driven straight from the two state registers, so each result appears one edge after its stimulus. The bench drives inputs on the falling edge and checks 2 ns after the next rising edge. This compares every vector against the state one register stage later. Mode changes reach `offset` without a clock, and the bench holds `lin_mode` steady across each checked burst.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_proc,
  input  logic             strobe_ctrl,
  input  logic             adv,
  input  logic             lin_mode,
  input  logic [OFS_W-1:0] start_addr,
  output logic [OFS_W-1:0] offset,
  output logic             last_beat
);
  localparam logic [OFS_W-1:0] LAST_K = {OFS_W{1'b1}};

  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] beat_q;
  logic             load;

  assign load = strobe_proc | strobe_ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      start_q <= start_addr;
      beat_q  <= '0;
    end else if (adv) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  assign offset    = lin_mode ? (start_q + beat_q) : (start_q ^ beat_q);
  assign last_beat = (beat_q == LAST_K);
endmodule

module burst_seq_chk #(
  parameter int OFS_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             strobe_proc,
  input logic             strobe_ctrl,
  input logic             adv,
  input logic             lin_mode,
  input logic [OFS_W-1:0] start_addr,
  input logic [OFS_W-1:0] offset,
  input logic             last_beat
);
  logic ld;
  assign ld = strobe_proc | strobe_ctrl;

  p_reset_r1: assert property (@(posedge clk) rst |=> (offset == '0 && !last_beat));

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    ld |=> (offset == $past(start_addr) && !last_beat));

  p_lin_step_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && !ld && lin_mode) |=> (!lin_mode || offset == OFS_W'($past(offset) + 1'b1)));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!adv && !ld) |=> ($stable(last_beat) && ($stable(offset) || lin_mode != $past(lin_mode))));

  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (adv && !ld && last_beat) |=> !last_beat);
endmodule

bind burst_seq burst_seq_chk #(.OFS_W(OFS_W)) u_chk (.*);

// File: tb/burst_seq_tb.sv
module burst_seq_tb;
  logic clk = 1'b0;
  logic rst, sp, sc, adv, mode;
  logic [1:0] addr;
  logic [1:0] offset;
  logic last_beat;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  burst_seq u_dut (
    .clk(clk), .rst(rst), .strobe_proc(sp), .strobe_ctrl(sc), .adv(adv),
    .lin_mode(mode), .start_addr(addr), .offset(offset), .last_beat(last_beat)
  );

  // {sp, sc, adv, mode, addr[1:0], exp_offset[1:0], exp_last}
  localparam int NV = 17;
  localparam logic [8:0] VEC [NV] = '{
    9'b1_0_0_0_01_01_0, // R2 processor strobe, start 1
    9'b0_0_1_0_00_00_0, // R3 interleaved beat1
    9'b0_0_1_0_00_11_0, // R3 beat2
    9'b0_0_1_0_00_10_1, // R7 beat3 last
    9'b0_0_1_0_00_01_0, // R8 wrap to start
    9'b0_0_0_0_11_01_0, // R5 hold
    9'b0_1_0_1_10_10_0, // R2 controller strobe, start 2
    9'b0_0_1_1_00_11_0, // R4 linear beat1
    9'b0_0_1_1_00_00_0, // R4 beat2
    9'b0_0_1_1_00_01_1, // R7 beat3 last
    9'b0_0_1_1_00_10_0, // R8 wrap
    9'b0_1_1_1_11_11_0, // R6 strobe beats adv
    9'b0_0_1_1_00_00_0, // R4 beat1 from 3
    9'b1_0_1_0_00_00_0, // R6 processor strobe with adv mid-burst
    9'b0_0_1_0_00_01_0, // R3
    9'b0_0_1_0_00_10_0, // R3
    9'b0_0_1_0_00_11_1  // R7
  };
  localparam int TAG [NV] = '{2,3,3,7,8,5,2,4,4,7,8,6,4,6,3,3,7};

  task automatic check(input int req, input logic [1:0] eo, input logic el);
    n_chk++;
    if (offset !== eo || last_beat !== el) begin
      n_bad++;
      $display("FAIL R%0d: offset=%0d last=%0b expected offset=%0d last=%0b",
               req, offset, last_beat, eo, el);
    end
  endtask

  task automatic step(input logic s_p, input logic s_c, input logic a,
                      input logic m, input logic [1:0] ad);
    @(negedge clk);
    sp = s_p; sc = s_c; adv = a; mode = m; addr = ad;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #150000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; sp = 0; sc = 0; adv = 0; mode = 0; addr = 0;
    repeat (2) @(posedge clk);
    #2;
    check(1, 2'd0, 1'b0); // R1 reset state
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4:3]);
      check(TAG[i], VEC[i][2:1], VEC[i][0]);
    end

    // R5 hold over several idle cycles on the last beat
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0, 0, 2'd1);
      check(5, 2'd3, 1'b1);
    end

    // R1 reset mid-burst with strobe present
    @(negedge clk); rst = 1'b1; sp = 1; addr = 2'd2;
    @(posedge clk); #2;
    check(1, 2'd0, 1'b0);
    @(negedge clk); rst = 1'b0; sp = 0;
    step(0, 0, 1, 1, 2'd0);
    check(1, 2'd1, 1'b0); // R1 captured start cleared to 0, linear beat1

    // R2 both strobes together
    step(1, 1, 0, 0, 2'd3);
    check(2, 2'd3, 1'b0);
    step(0, 0, 1, 0, 2'd0);
    check(3, 2'd2, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule